// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM with Separate Read and Write Ports

This block is a synthesizable model of a synchronous static memory with one read port and one write port. The two ports have their own active-low selects and share one address bus. Two complementary input clocks, `clk_k` and `clk_kn`, pace every transfer, so data moves on the rising edge of each. Every access moves a fixed pair of words.

A write is requested on a `clk_k` rise. The first data beat and its lane masks are taken on that same edge. The pair address and the second beat are taken on the next `clk_kn` rise. A read is requested on a `clk_k` rise together with its pair address. The two words come back one `clk_k` period later, the even word on a `clk_k` rise and the odd word on the following `clk_kn` rise. While no burst is being returned, the data bus is zero. The output `rdata_oe` stands in for the tri-state control of a real pad.

The storage is split into an even half and an odd half. Each half holds one word of every pair. A read and a write may start in the same cycle. If both target the same pair, the read returns the freshly written words, merged under the lane masks.

Top module: `ddrb2_sram`

## Requirements
- R1: While reset is held, and until the first read has been requested, `rdata_oe` is low and `rdata` is all zero.
- R2: When `rd_sel_n` is low at a `clk_k` rise, the even word of the addressed pair is on `rdata` from the next `clk_k` rise. The odd word follows from the `clk_kn` rise after that. `rdata_oe` is high over both beats.
- R3: When `wr_sel_n` is low at a `clk_k` rise, the write takes `addr` at the following `clk_kn` rise as the pair address `a`. The data beat taken at the `clk_k` rise is stored to word 2a, which a read returns as its first beat. The data beat taken at the `clk_kn` rise is stored to word 2a+1, which a read returns as its second beat.
- R4: Bit `wr_lane_n[i]` low writes lane i, which is bits 9i+8 down to 9i. The bit is taken on the same edge as the data beat it qualifies, so each beat has its own mask. A lane whose bit is high keeps its stored value.
- R5: When `wr_sel_n` is high at a `clk_k` rise, the values on `wdata`, `wr_lane_n` and `addr` during that cycle change no stored word.
- R6: The read pair address is taken only at the `clk_k` rise. The value of `addr` at the following `clk_kn` rise has no effect on the read.
- R7: A read and a write requested on the same `clk_k` rise to the same pair return the contents after that write, merged lane by lane.
- R8: A cycle without a read request is followed by a `clk_k` period in which `rdata_oe` is low. While `rdata_oe` is low, `rdata` is zero.
- R9: Reads requested on consecutive `clk_k` rises give back-to-back bursts, with `rdata_oe` held high across the boundary between them.
- R10: A read and a write requested on the same edge to different pairs do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Primary clock; requests, read address and first write beat are taken on its rise |
| clk_kn | input | 1 | Complement of `clk_k`; write address and second write beat are taken on its rise |
| rst_n | input | 1 | Asynchronous active-low reset, released inside on `clk_k` |
| rd_sel_n | input | 1 | Active-low read request |
| wr_sel_n | input | 1 | Active-low write request |
| addr | input | AW | Shared pair address: read address at `clk_k`, write address at `clk_kn` |
| wdata | input | LANES*9 | Write data, one beat per clock rise |
| wr_lane_n | input | LANES | Active-low per-lane write enables, one set per beat |
| rdata | output | LANES*9 | Read data, even word then odd word |
| rdata_oe | output | 1 | High while a read burst is driven |

## Verification
The bench first fills every pair with full-lane writes and then reads all of them back to back. This shows whether the beats land in the right half and whether the bursts abut without a gap. Writes with assorted per-beat lane masks separate a mask taken on the wrong edge from a mask applied to the wrong lane. Deselected writes that carry busy data and address test that the store is untouched, and a toggling `addr` at the `clk_kn` rise of read cycles tests that the read address is taken only at `clk_k`. Same-pair and different-pair concurrent reads and writes, isolated reads with gaps, and a long random mix then compare every half-cycle of the bus against a reference memory.

// File: rtl/ddrb2_pkg.sv
`timescale 1ns/1ps
package ddrb2_pkg;
  // width of one byte lane including its parity-style ninth bit
  parameter int unsigned LANE_W = 9;
  // which half of the array holds a beat of the burst
  typedef enum logic {
    HALF_EVEN = 1'b0,
    HALF_ODD  = 1'b1
  } half_e;
endpackage

// File: rtl/ddrb2_rst_sync.sv
`timescale 1ns/1ps
module ddrb2_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/ddrb2_lane_merge.sv
`timescale 1ns/1ps
module ddrb2_lane_merge #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = ddrb2_pkg::LANE_W,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic [DW-1:0]    old_d,
  input  logic [DW-1:0]    new_d,
  input  logic [LANES-1:0] keep_n,
  output logic [DW-1:0]    out_d
);
  // a low keep_n bit takes the new lane, a high bit keeps the old one
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign out_d[i*LANE_W +: LANE_W] = keep_n[i] ? old_d[i*LANE_W +: LANE_W]
                                                 : new_d[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ddrb2_bank.sv
`timescale 1ns/1ps
module ddrb2_bank #(
  parameter int unsigned AW     = 4,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = ddrb2_pkg::LANE_W,
  localparam int unsigned DW    = LANES * LANE_W,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wlane_n,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] cur_word;
  logic [DW-1:0] merged;

  assign cur_word = mem[waddr];

  ddrb2_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_wmerge (
    .old_d  (cur_word),
    .new_d  (wdata),
    .keep_n (wlane_n),
    .out_d  (merged)
  );

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= merged;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ddrb2_wr_capture.sv
`timescale 1ns/1ps
module ddrb2_wr_capture #(
  parameter int unsigned AW     = 4,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = ddrb2_pkg::LANE_W,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk_k,
  input  logic             clk_kn,
  input  logic             rst_core_n,
  input  logic             wr_sel_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wr_lane_n,
  output logic             wr_go_q,
  output logic [AW-1:0]    waddr_q,
  output logic [DW-1:0]    wd0_q,
  output logic [LANES-1:0] wm0_q,
  output logic [DW-1:0]    wd1_q,
  output logic [LANES-1:0] wm1_q
);
  logic             wr_go_d;
  logic             beat0_en;
  logic             beat1_en;
  logic [DW-1:0]    wd0_d;
  logic [LANES-1:0] wm0_d;
  logic [AW-1:0]    waddr_d;
  logic [DW-1:0]    wd1_d;
  logic [LANES-1:0] wm1_d;

  // clk_k side: request and first beat
  always_comb begin
    wr_go_d  = ~wr_sel_n;
    beat0_en = ~wr_sel_n;
    wd0_d    = beat0_en ? wdata     : wd0_q;
    wm0_d    = beat0_en ? wr_lane_n : wm0_q;
  end

  always_ff @(posedge clk_k or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wr_go_q <= 1'b0;
    end else begin
      wr_go_q <= wr_go_d;
    end
  end

  always_ff @(posedge clk_k) begin
    wd0_q <= wd0_d;
    wm0_q <= wm0_d;
  end

  // clk_kn side: pair address and second beat of the request just taken
  always_comb begin
    beat1_en = wr_go_q;
    waddr_d  = beat1_en ? addr      : waddr_q;
    wd1_d    = beat1_en ? wdata     : wd1_q;
    wm1_d    = beat1_en ? wr_lane_n : wm1_q;
  end

  always_ff @(posedge clk_kn) begin
    waddr_q <= waddr_d;
    wd1_q   <= wd1_d;
    wm1_q   <= wm1_d;
  end
endmodule

// File: rtl/ddrb2_rd_path.sv
`timescale 1ns/1ps
module ddrb2_rd_path #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 18
) (
  input  logic          clk_k,
  input  logic          clk_kn,
  input  logic          rst_core_n,
  input  logic          rd_sel_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] even_d,
  input  logic [DW-1:0] odd_d,
  output logic          rd_go_q,
  output logic [AW-1:0] raddr_q,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe
);
  logic          rd_go_d;
  logic [AW-1:0] raddr_d;
  logic          oe_q;
  logic          oe_d;
  logic [DW-1:0] beat0_q;
  logic [DW-1:0] beat0_d;
  logic [DW-1:0] hold1_q;
  logic [DW-1:0] hold1_d;
  logic [DW-1:0] beat1_q;
  logic [DW-1:0] beat1_d;

  always_comb begin
    rd_go_d = ~rd_sel_n;
    raddr_d = rd_sel_n ? raddr_q : addr;
    oe_d    = rd_go_q;
    beat0_d = rd_go_q ? even_d : beat0_q;
    hold1_d = rd_go_q ? odd_d  : hold1_q;
  end

  always_ff @(posedge clk_k or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rd_go_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      rd_go_q <= rd_go_d;
      oe_q    <= oe_d;
    end
  end

  always_ff @(posedge clk_k) begin
    raddr_q <= raddr_d;
    beat0_q <= beat0_d;
    hold1_q <= hold1_d;
  end

  // second beat moves to its own register on the complementary edge
  always_comb begin
    beat1_d = oe_q ? hold1_q : beat1_q;
  end

  always_ff @(posedge clk_kn) begin
    beat1_q <= beat1_d;
  end

  // single-clock mode: clk_k high selects the first beat, low the second
  assign rdata    = oe_q ? (clk_k ? beat0_q : beat1_q) : '0;
  assign rdata_oe = oe_q;
endmodule

// File: rtl/ddrb2_sram.sv
`timescale 1ns/1ps
module ddrb2_sram #(
  parameter int unsigned AW     = 4,
  parameter int unsigned LANES  = 2,
  localparam int unsigned LANE_W = ddrb2_pkg::LANE_W,
  localparam int unsigned DW     = LANES * LANE_W
) (
  input  logic             clk_k,
  input  logic             clk_kn,
  input  logic             rst_n,
  input  logic             rd_sel_n,
  input  logic             wr_sel_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wr_lane_n,
  output logic [DW-1:0]    rdata,
  output logic             rdata_oe
);
  import ddrb2_pkg::*;

  logic             rst_core_n;
  logic             wr_go;
  logic [AW-1:0]    waddr_q;
  logic [DW-1:0]    wd0_q;
  logic [LANES-1:0] wm0_q;
  logic [DW-1:0]    wd1_q;
  logic [LANES-1:0] wm1_q;
  logic             rd_go;
  logic [AW-1:0]    raddr_q;
  logic             fwd_hit;
  logic [DW-1:0]    half_wd  [2];
  logic [LANES-1:0] half_wm  [2];
  logic [DW-1:0]    half_rd  [2];
  logic [DW-1:0]    half_fwd [2];

  ddrb2_rst_sync u_rst (
    .clk    (clk_k),
    .arst_n (rst_n),
    .srst_n (rst_core_n)
  );

  ddrb2_wr_capture #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_wr (
    .clk_k      (clk_k),
    .clk_kn     (clk_kn),
    .rst_core_n (rst_core_n),
    .wr_sel_n   (wr_sel_n),
    .addr       (addr),
    .wdata      (wdata),
    .wr_lane_n  (wr_lane_n),
    .wr_go_q    (wr_go),
    .waddr_q    (waddr_q),
    .wd0_q      (wd0_q),
    .wm0_q      (wm0_q),
    .wd1_q      (wd1_q),
    .wm1_q      (wm1_q)
  );

  // a write still waiting to commit that hits the pair being read
  assign fwd_hit = wr_go & (waddr_q == raddr_q);

  assign half_wd[HALF_EVEN] = wd0_q;
  assign half_wm[HALF_EVEN] = wm0_q;
  assign half_wd[HALF_ODD]  = wd1_q;
  assign half_wm[HALF_ODD]  = wm1_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [LANES-1:0] fwd_keep_n;

    ddrb2_bank #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_bank (
      .clk     (clk_k),
      .we      (wr_go),
      .waddr   (waddr_q),
      .wdata   (half_wd[h]),
      .wlane_n (half_wm[h]),
      .raddr   (raddr_q),
      .rdata   (half_rd[h])
    );

    assign fwd_keep_n = fwd_hit ? half_wm[h] : {LANES{1'b1}};

    ddrb2_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_fwd (
      .old_d  (half_rd[h]),
      .new_d  (half_wd[h]),
      .keep_n (fwd_keep_n),
      .out_d  (half_fwd[h])
    );
  end

  ddrb2_rd_path #(.AW(AW), .DW(DW)) u_rd (
    .clk_k      (clk_k),
    .clk_kn     (clk_kn),
    .rst_core_n (rst_core_n),
    .rd_sel_n   (rd_sel_n),
    .addr       (addr),
    .even_d     (half_fwd[HALF_EVEN]),
    .odd_d      (half_fwd[HALF_ODD]),
    .rd_go_q    (rd_go),
    .raddr_q    (raddr_q),
    .rdata      (rdata),
    .rdata_oe   (rdata_oe)
  );
endmodule

// File: rtl/ddrb2_sram_chk.sv
`timescale 1ns/1ps
module ddrb2_sram_chk #(
  parameter int unsigned DW = 18
) (
  input logic          clk_k,
  input logic          clk_kn,
  input logic          rst_core_n,
  input logic          rd_sel_n,
  input logic          wr_sel_n,
  input logic          bank_we,
  input logic [DW-1:0] rdata,
  input logic          rdata_oe
);
  AST_RESET_QUIET: assert property (@(posedge clk_k)
    !rst_core_n |-> (!rdata_oe && rdata == '0)); // R1

  AST_READ_DRIVES_BUS: assert property (@(posedge clk_k) disable iff (!rst_core_n)
    !rd_sel_n |-> ##2 rdata_oe); // R2

  AST_NO_READ_NO_DRIVE: assert property (@(posedge clk_k) disable iff (!rst_core_n)
    rd_sel_n |-> ##2 !rdata_oe); // R8

  AST_IDLE_ZERO_K: assert property (@(posedge clk_k) disable iff (!rst_core_n)
    !rdata_oe |-> rdata == '0); // R8

  AST_IDLE_ZERO_KN: assert property (@(posedge clk_kn) disable iff (!rst_core_n)
    !rdata_oe |-> rdata == '0); // R8

  AST_DESELECT_NO_COMMIT: assert property (@(posedge clk_k) disable iff (!rst_core_n)
    wr_sel_n |=> !bank_we); // R5
endmodule

bind ddrb2_sram ddrb2_sram_chk #(.DW(DW)) u_chk (
  .clk_k      (clk_k),
  .clk_kn     (clk_kn),
  .rst_core_n (rst_core_n),
  .rd_sel_n   (rd_sel_n),
  .wr_sel_n   (wr_sel_n),
  .bank_we    (wr_go),
  .rdata      (rdata),
  .rdata_oe   (rdata_oe)
);

// File: tb/ddrb2_sram_test.sv
`timescale 1ns/1ps
module ddrb2_sram_test;
  localparam int AW    = 4;
  localparam int LANES = 2;
  localparam int DW    = LANES * 9;
  localparam int PAIRS = 1 << AW;

  logic             clk_k = 1'b0;
  logic             clk_kn;
  logic             rst_n = 1'b1;
  logic             rd_sel_n = 1'b1;
  logic             wr_sel_n = 1'b1;
  logic [AW-1:0]    addr = '0;
  logic [DW-1:0]    wdata = '0;
  logic [LANES-1:0] wr_lane_n = '1;
  logic [DW-1:0]    rdata;
  logic             rdata_oe;

  int n_checks = 0;
  int n_fail   = 0;
  int n_cyc    = 0;
  string cur_req = "R1";
  bit mon_on = 1'b0;

  logic [DW-1:0] ref_mem [2*PAIRS];

  // expectation pipeline: request of a cycle, then the burst one cycle later
  bit            req_v = 1'b0;
  logic [DW-1:0] req_d0 = '0;
  logic [DW-1:0] req_d1 = '0;
  bit            stg_v = 1'b0;
  logic [DW-1:0] stg_d0 = '0;
  logic [DW-1:0] stg_d1 = '0;
  bit            exp_v;
  logic [DW-1:0] exp_d0;
  logic [DW-1:0] exp_d1;

  always #2 clk_k = ~clk_k;   // 250 MHz
  assign clk_kn = ~clk_k;

  ddrb2_sram #(.AW(AW), .LANES(LANES)) uut (
    .clk_k     (clk_k),
    .clk_kn    (clk_kn),
    .rst_n     (rst_n),
    .rd_sel_n  (rd_sel_n),
    .wr_sel_n  (wr_sel_n),
    .addr      (addr),
    .wdata     (wdata),
    .wr_lane_n (wr_lane_n),
    .rdata     (rdata),
    .rdata_oe  (rdata_oe)
  );

  function automatic logic [DW-1:0] merge(logic [DW-1:0] o, logic [DW-1:0] n,
                                          logic [LANES-1:0] m);
    logic [DW-1:0] r = o;
    for (int i = 0; i < LANES; i++)
      if (!m[i]) r[i*9 +: 9] = n[i*9 +: 9];
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic oe_a, logic [DW-1:0] d_a,
                       logic oe_e, logic [DW-1:0] d_e);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: oe=%0b data=%h, expected oe=%0b data=%h",
               tag, oe_a, d_a, oe_e, d_e);
    end
  endtask

  // one clk_k period: request inputs before the clk_k rise, second half before clk_kn rise
  task automatic cyc(bit rd, int ra, bit wr, int wa,
                     logic [DW-1:0] d0, logic [DW-1:0] d1,
                     logic [LANES-1:0] m0, logic [LANES-1:0] m1);
    @(posedge clk_kn); #1;
    rd_sel_n  = !rd;
    wr_sel_n  = !wr;
    addr      = AW'(ra);
    wdata     = d0;
    wr_lane_n = m0;
    if (wr) begin
      ref_mem[2*wa]   = merge(ref_mem[2*wa],   d0, m0);
      ref_mem[2*wa+1] = merge(ref_mem[2*wa+1], d1, m1);
    end
    req_v  = rd;
    req_d0 = rd ? ref_mem[2*ra]   : '0;
    req_d1 = rd ? ref_mem[2*ra+1] : '0;
    @(posedge clk_k); #1;
    addr      = AW'(wa);
    wdata     = d1;
    wr_lane_n = m1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++)
      cyc(0, $urandom % PAIRS, 0, $urandom % PAIRS, DW'($urandom), DW'($urandom),
          LANES'($urandom), LANES'($urandom));
  endtask

  function automatic logic [DW-1:0] rnd();
    return DW'($urandom);
  endfunction

  // reference comparison on every clock edge
  always begin
    @(posedge clk_k); #0.5;
    exp_v = stg_v; exp_d0 = stg_d0; exp_d1 = stg_d1;
    stg_v = req_v; stg_d0 = req_d0; stg_d1 = req_d1;
    if (mon_on)
      check(rdata_oe === exp_v && rdata === (exp_v ? exp_d0 : '0),
            {cur_req, " beat0"}, rdata_oe, rdata, exp_v, exp_v ? exp_d0 : '0);
    @(posedge clk_kn); #0.5;
    if (mon_on)
      check(rdata_oe === exp_v && rdata === (exp_v ? exp_d1 : '0),
            {cur_req, " beat1"}, rdata_oe, rdata, exp_v, exp_v ? exp_d1 : '0);
  end

  // watchdog
  always @(posedge clk_k) begin
    n_cyc++;
    if (n_cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #0.1 rst_n = 1'b0;
    // R1: bus quiet while reset is held
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_k); #0.5;
      check(rdata_oe === 1'b0 && rdata === '0, "R1 reset", rdata_oe, rdata, 1'b0, '0);
    end
    @(posedge clk_kn); #1 rst_n = 1'b1;
    mon_on = 1'b1;
    idle(4);

    cur_req = "R3";   // fill all pairs with full-lane writes
    for (int p = 0; p < PAIRS; p++)
      cyc(0, 0, 1, p, rnd(), rnd(), '0, '0);
    idle(2);

    cur_req = "R9";   // back-to-back reads of every pair (also R2)
    for (int p = 0; p < PAIRS; p++)
      cyc(1, p, 0, (p + 5) % PAIRS, rnd(), rnd(), '0, '0);
    idle(2);

    cur_req = "R4";   // per-beat lane masks
    for (int p = 0; p < 8; p++) begin
      cyc(0, 0, 1, p, rnd(), rnd(), LANES'(p), LANES'(p >> 1));
      idle(1);
      cyc(1, p, 0, 0, '0, '0, '1, '1);
      idle(1);
    end

    cur_req = "R5";   // deselected writes with busy bus
    for (int p = 0; p < 6; p++)
      cyc(0, 0, 0, p, rnd(), rnd(), '0, '0);
    for (int p = 0; p < 6; p++)
      cyc(1, p, 0, 0, '0, '0, '1, '1);
    idle(2);

    cur_req = "R6";   // addr changes at clk_kn of read cycles
    for (int p = 0; p < 6; p++)
      cyc(1, p, 0, PAIRS - 1 - p, rnd(), rnd(), '0, '0);
    idle(2);

    cur_req = "R7";   // same-pair read and write on one edge
    for (int p = 0; p < 6; p++) begin
      cyc(1, p, 1, p, rnd(), rnd(), LANES'(p + 1), LANES'(p + 2));
      idle(1);
    end
    for (int p = 0; p < 4; p++)
      cyc(1, 3, 1, 3, rnd(), rnd(), LANES'(p), LANES'(3 - p));
    idle(2);

    cur_req = "R10";  // concurrent read and write to different pairs
    for (int p = 0; p < 6; p++)
      cyc(1, p, 1, p + 8, rnd(), rnd(), '0, '0);
    idle(2);

    cur_req = "R8";   // isolated reads with gaps
    for (int p = 0; p < 4; p++) begin
      cyc(1, p * 3, 0, 0, '0, '0, '1, '1);
      idle(p + 1);
    end

    cur_req = "R2";   // random mix of everything
    for (int i = 0; i < 400; i++)
      cyc(($urandom % 3) != 0, $urandom % PAIRS, ($urandom % 2) == 0, $urandom % PAIRS,
          rnd(), rnd(), LANES'($urandom), LANES'($urandom));
    idle(4);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule